// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block takes the configuration writes aimed at an eight-input programmable interrupt controller. It walks through up to four initialization words and keeps the fields each word carries. The first word is recognised on the data bus at any time by its tag bit. Two flags in that word then decide whether the third word (cascade setup) and the fourth word (mode setup) are expected. A full setup therefore takes anywhere from two to four writes.

The sequencer outputs the decoded fields and a ready flag. The ready flag tells the rest of the controller that it may start taking interrupts. The current sequencer state is also visible on an encoded port, so each skip path can be observed from outside.

Top module: `irq_init_seq`

## Requirements
- R1: After synchronous reset the state is idle (code 0), ready is low, every stored field is zero and the trigger mode is edge (level_mode = 0).
- R2: A write with a0 = 0 and data bit 4 = 1 is a first word in any state. It captures level_mode = bit 3, single_mode = bit 1, word4_req = bit 0 and vec_low = bits 7..5. It clears cascade_cfg, mode_cfg and ready, and enters state 1 (awaiting word 2).
- R3: In state 1, the next write with a0 = 1 stores all eight data bits into vec_high.
- R4: After word 2, if single_mode is 0 the state becomes 2 (awaiting word 3). The next a0 = 1 write in state 2 stores its data into cascade_cfg.
- R5: After word 2 (single_mode = 1) or word 3, if word4_req is 1 the state becomes 3 (awaiting word 4). The next a0 = 1 write in state 3 stores its data into mode_cfg.
- R6: Ready (state 4) follows the last required word immediately. That means after word 2 when both optional words are skipped, after word 3 when word 4 is skipped, and after word 4 otherwise. The full setup takes 2, 3 or 4 writes.
- R7: In idle or ready, any write that is not a first word changes no stored field and no state. During the sequence, an a0 = 0 write without bit 4 set is also ignored.
- R8: The write strobe is acted on only at its rising transition as seen at a clock edge. A strobe held high for several cycles counts as one write.
- R9: seq_state encodes 0 idle, 1 awaiting word 2, 2 awaiting word 3, 3 awaiting word 4, 4 ready. ready is high exactly in state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe, acted on at its rising transition |
| a0 | input | 1 | Address select line |
| din | input | 8 | Write data bus |
| level_mode | output | 1 | 1 = level-sensitive requests, 0 = rising-edge |
| single_mode | output | 1 | 1 = single controller, word 3 skipped |
| word4_req | output | 1 | 1 = word 4 expected |
| vec_low | output | 3 | Vector address bits 7..5 from word 1 |
| vec_high | output | 8 | Vector address bits 15..8 from word 2 |
| cascade_cfg | output | 8 | Cascade configuration byte from word 3 |
| mode_cfg | output | 8 | Mode byte from word 4 |
| ready | output | 1 | Initialization complete |
| seq_state | output | 3 | Encoded sequencer state |

## Verification
The bench sweeps all eight combinations of trigger mode, single and word-4 flags, with varying vector bits, and checks the state after every write. A design that mixed up the skip flags would stop in the wrong state or become ready one write early or late. A strobe is held high across several cycles while the data changes. A level-acting design would consume the following words and finish the sequence with the wrong bytes. Restarts in the middle of the sequence, and stray writes while idle or ready, are checked for cleared cascade and mode bytes and for unchanged fields respectively.

// File: rtl/irq_init_pkg.sv
package irq_init_pkg;
    localparam int DATA_W   = 8;
    localparam int VLO_W    = 3;
    localparam int ST_W     = 3;
    localparam int TAG_BIT  = 4;
    localparam int LVL_BIT  = 3;
    localparam int SNGL_BIT = 1;
    localparam int W4_BIT   = 0;
    localparam int VLO_LSB  = DATA_W - VLO_W;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'd0,
        ST_W2   = 3'd1,
        ST_W3   = 3'd2,
        ST_W4   = 3'd3,
        ST_RDY  = 3'd4
    } seq_st_t;

    typedef struct packed {
        logic             level;
        logic             single;
        logic             need4;
        logic [VLO_W-1:0] vlo;
    } w1_fields_t;

    typedef struct packed {
        logic w1;
        logic w2;
        logic w3;
        logic w4;
    } load_t;

    function automatic logic is_first_word(input logic sel, input logic [DATA_W-1:0] d);
        return !sel && d[TAG_BIT];
    endfunction

    function automatic w1_fields_t split_w1(input logic [DATA_W-1:0] d);
        w1_fields_t f;
        f.level  = d[LVL_BIT];
        f.single = d[SNGL_BIT];
        f.need4  = d[W4_BIT];
        f.vlo    = d[DATA_W-1:VLO_LSB];
        return f;
    endfunction
endpackage

// File: rtl/irq_wr_edge.sv
module irq_wr_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic pulse
);
    logic stb_q;

    // Tracks the strobe through reset so a strobe held across reset is not a new write
    always_ff @(posedge clk) begin
        stb_q <= stb;
    end

    assign pulse = stb && !stb_q && !rst;
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
    import irq_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    input  logic              single,
    input  logic              need4,
    output seq_st_t           state,
    output load_t             ld
);
    seq_st_t nxt;
    logic    first;
    logic    upper;

    assign first = wr && is_first_word(a0, din);
    assign upper = wr && a0;

    always_comb begin
        nxt = state;
        ld  = '0;
        if (first) begin
            ld.w1 = 1'b1;
            nxt   = ST_W2;
        end else if (upper) begin
            unique case (state)
                ST_W2: begin
                    ld.w2 = 1'b1;
                    if (!single)    nxt = ST_W3;
                    else if (need4) nxt = ST_W4;
                    else            nxt = ST_RDY;
                end
                ST_W3: begin
                    ld.w3 = 1'b1;
                    nxt   = need4 ? ST_W4 : ST_RDY;
                end
                ST_W4: begin
                    ld.w4 = 1'b1;
                    nxt   = ST_RDY;
                end
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/irq_init_regs.sv
module irq_init_regs
    import irq_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  load_t             ld,
    input  logic [DATA_W-1:0] din,
    output w1_fields_t        w1,
    output logic [DATA_W-1:0] vhi,
    output logic [DATA_W-1:0] casc,
    output logic [DATA_W-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            w1   <= '0;
            vhi  <= '0;
            casc <= '0;
            mode <= '0;
        end else begin
            if (ld.w1) begin
                w1   <= split_w1(din);
                casc <= '0;
                mode <= '0;
            end
            if (ld.w2) vhi  <= din;
            if (ld.w3) casc <= din;
            if (ld.w4) mode <= din;
        end
    end
endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output logic              level_mode,
    output logic              single_mode,
    output logic              word4_req,
    output logic [VLO_W-1:0]  vec_low,
    output logic [DATA_W-1:0] vec_high,
    output logic [DATA_W-1:0] cascade_cfg,
    output logic [DATA_W-1:0] mode_cfg,
    output logic              ready,
    output logic [ST_W-1:0]   seq_state
);
    logic       wr_pulse;
    seq_st_t    st;
    load_t      ld;
    w1_fields_t w1;

    irq_wr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .stb   (wr_stb),
        .pulse (wr_pulse)
    );

    irq_init_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_pulse),
        .a0     (a0),
        .din    (din),
        .single (w1.single),
        .need4  (w1.need4),
        .state  (st),
        .ld     (ld)
    );

    irq_init_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .ld   (ld),
        .din  (din),
        .w1   (w1),
        .vhi  (vec_high),
        .casc (cascade_cfg),
        .mode (mode_cfg)
    );

    assign level_mode  = w1.level;
    assign single_mode = w1.single;
    assign word4_req   = w1.need4;
    assign vec_low     = w1.vlo;
    assign seq_state   = st;
    assign ready       = (st == ST_RDY);
endmodule

// File: rtl/irq_init_seq_chk.sv
module irq_init_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic       a0,
    input logic [7:0] din,
    input logic       single_mode,
    input logic       word4_req,
    input logic       level_mode,
    input logic [7:0] vec_high,
    input logic [7:0] cascade_cfg,
    input logic [7:0] mode_cfg,
    input logic       ready,
    input logic [2:0] seq_state
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (seq_state == 3'd0 && !ready && vec_high == 8'd0)); // R1

    AST_FIRST_RESTART: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_stb) && !a0 && din[4]) |=>
            (seq_state == 3'd1 && !ready && cascade_cfg == 8'd0 && mode_cfg == 8'd0)); // R2

    AST_W3_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_stb) && a0 && seq_state == 3'd2) |=> (cascade_cfg == $past(din))); // R4

    AST_FULL_SKIP: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_stb) && a0 && seq_state == 3'd1 && single_mode && !word4_req) |=> ready); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_stb) && !(!a0 && din[4]) && (seq_state == 3'd0 || seq_state == 3'd4)) |=>
            ($stable(vec_high) && $stable(cascade_cfg) && $stable(mode_cfg) &&
             $stable(level_mode) && $stable(seq_state))); // R7

    AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!rst && !$rose(wr_stb)) |=> ($stable(seq_state) && $stable(mode_cfg))); // R8

    AST_READY_CODE: assert property (@(posedge clk) disable iff (rst)
        ready |-> (seq_state == 3'd4)); // R9
endmodule

bind irq_init_seq irq_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .a0          (a0),
    .din         (din),
    .single_mode (single_mode),
    .word4_req   (word4_req),
    .level_mode  (level_mode),
    .vec_high    (vec_high),
    .cascade_cfg (cascade_cfg),
    .mode_cfg    (mode_cfg),
    .ready       (ready),
    .seq_state   (seq_state)
);

// File: tb/irq_init_seq_test.sv
module irq_init_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic       a0 = 1'b0;
    logic [7:0] din = 8'd0;
    logic       level_mode, single_mode, word4_req, ready;
    logic [2:0] vec_low, seq_state;
    logic [7:0] vec_high, cascade_cfg, mode_cfg;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_init_seq uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .a0(a0), .din(din),
        .level_mode(level_mode), .single_mode(single_mode), .word4_req(word4_req),
        .vec_low(vec_low), .vec_high(vec_high), .cascade_cfg(cascade_cfg),
        .mode_cfg(mode_cfg), .ready(ready), .seq_state(seq_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Inputs change at negedge; the write takes effect at the following posedge
    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        a0 = sel; din = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 state", seq_state, 0);
        chk_eq("R1 ready", ready, 0);
        chk_eq("R1 level", level_mode, 0);
        chk_eq("R1 fields", {vec_low, vec_high, cascade_cfg, mode_cfg}, 0);

        // R7 stray writes while idle
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'hEF & 8'hEF);
        chk_eq("R7 idle state", seq_state, 0);
        chk_eq("R7 idle fields", {vec_high, cascade_cfg, mode_cfg}, 0);

        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 2; v++) begin
                logic [7:0] w1, w2, w3, w4;
                int exp_wr;
                bit lvl, sng, n4;
                lvl = f[2]; sng = f[1]; n4 = f[0];
                w1 = {3'(f + 3*v), 1'b1, lvl, 1'b0, sng, n4};
                w2 = 8'(8'h11 * (f + 1) + v);
                w3 = 8'(8'hC3 ^ (f * 7 + v));
                w4 = 8'(8'h3C + f + 16*v);
                exp_wr = 2 + (sng ? 0 : 1) + (n4 ? 1 : 0);

                wr(1'b0, w1);
                chk_eq("R2 state", seq_state, 1);
                chk_eq("R2 fields", {level_mode, single_mode, word4_req, vec_low},
                       {lvl, sng, n4, w1[7:5]});
                chk_eq("R2 cleared", {ready, cascade_cfg, mode_cfg}, 0);

                // R7: a0=0 write without tag bit is ignored mid-sequence
                wr(1'b0, 8'h0F);
                chk_eq("R7 mid ignore", seq_state, 1);

                if (v == 1) begin
                    // R8: strobe held three cycles while data changes
                    @(negedge clk); a0 = 1'b1; din = w2; wr_stb = 1'b1;
                    @(negedge clk); din = w3;
                    @(negedge clk); din = w4;
                    @(negedge clk); wr_stb = 1'b0;
                    chk_eq("R8 held once", vec_high, w2);
                    chk_eq("R8 held state", seq_state, !sng ? 2 : (n4 ? 3 : 4));
                    chk_eq("R8 casc untouched", cascade_cfg, 0);
                end else begin
                    wr(1'b1, w2);
                    chk_eq("R3 vec_high", vec_high, w2);
                end
                chk_eq("R6 after w2", seq_state, !sng ? 2 : (n4 ? 3 : 4));
                if (!sng) begin
                    wr(1'b1, w3);
                    chk_eq("R4 cascade", cascade_cfg, w3);
                    chk_eq("R6 after w3", seq_state, n4 ? 3 : 4);
                end
                if (n4) begin
                    wr(1'b1, w4);
                    chk_eq("R5 mode", mode_cfg, w4);
                end
                chk_eq("R6 ready", ready, 1);
                chk_eq("R9 code", seq_state, 4);
                chk_eq("R6 count", exp_wr, 2 + (!sng ? 1 : 0) + (n4 ? 1 : 0));
                chk_eq("R5 mode skipped", mode_cfg, n4 ? w4 : 0);

                // R7 stray writes when ready
                wr(1'b1, 8'hA5);
                wr(1'b0, 8'h07);
                chk_eq("R7 ready hold", {seq_state, vec_high, cascade_cfg, mode_cfg},
                       {3'd4, vec_high == 8'hA5 ? 8'h00 : (v == 1 ? w2 : w2),
                        (!sng) ? w3 : 8'h00, n4 ? w4 : 8'h00});
            end
        end

        // R2 restart in the middle of the sequence clears cascade byte
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h22);
        wr(1'b1, 8'h33);
        chk_eq("R2 pre-restart casc", cascade_cfg, 8'h33);
        wr(1'b0, 8'h19);
        chk_eq("R2 restart state", seq_state, 1);
        chk_eq("R2 restart clear", {cascade_cfg, mode_cfg, ready}, 0);
        chk_eq("R2 restart level", level_mode, 1);

        // R1 reset again from mid-sequence
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk_eq("R1 re-reset", {seq_state, level_mode, vec_high}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule